// File: doc/BRIEF.md
# Guarded Accumulator with Saturating View and Shift Commands

This block keeps a 40-bit signed running sum for a multiply-accumulate datapath. A sequencer presents one 32-bit signed product per cycle on a strobed input. Each product is sign-extended and added into the sum. The eight bits above the 32-bit word act as guard bits, so a long run of products can grow past the signed 32-bit range without being lost.

Software reaches the sum through a small register window. The low word and the guard byte can each be read and written on their own. Sign extension is applied automatically in both directions. A read-only view returns the sum clamped to the signed 32-bit range, and reading it does not disturb the stored value. A write-only command register scales the sum by fixed arithmetic right shifts or zero-filling left shifts. Bus writes take effect at the clock edge. Reads are combinational from the address.

Top module: `acc40_unit`

## Requirements
- R1: After reset the sum is zero, so reads of the low word (0x14), the guard word (0x18) and the clamp view (0x1C) all return 0.
- R2: When a product is strobed and no bus write targets 0x08, 0x14 or 0x18, the product is sign-extended to 40 bits and added modulo 2^40. The sum wraps and never saturates.
- R3: A write to 0x14 loads sum bits 31:0 from the written data and fills bits 39:32 with copies of data bit 31. A read of 0x14 returns sum bits 31:0.
- R4: A write to 0x18 loads sum bits 39:32 from data bits 7:0. Data bits 31:8 are ignored, and sum bits 31:0 keep their value.
- R5: A read of 0x18 returns sum bits 39:32 in bits 7:0, with bits 31:8 holding copies of sum bit 39.
- R6: A read of 0x1C returns 0x7FFF_FFFF when the signed sum is above 2^31-1 and 0x8000_0000 when it is below -2^31. Otherwise it returns sum bits 31:0. The sum itself is not changed.
- R7: Data bits 3:0 of a write to 0x08 form a command. 0000 leaves the sum as it is, 0001 shifts right by 1, 0100 shifts right by 4, 1001 shifts left by 1 and 1100 shifts left by 4. Right shifts copy bit 39 into the vacated bits. Left shifts fill with zero and drop bits shifted out of bit 39.
- R8: A write to 0x08 with any other command code leaves the sum unchanged.
- R9: A bus write to 0x08, 0x14 or 0x18 in the same cycle as a product strobe wins. That product is discarded, and this also holds for a reserved shift code.
- R10: Reads of any offset other than 0x14, 0x18 and 0x1C return 0. Writes to any offset other than 0x08, 0x14 and 0x18 have no effect, and a product strobed in the same cycle is still added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 5 | Register byte offset for both read and write |
| wr_en_i | input | 1 | Bus write strobe |
| wdata_i | input | 32 | Bus write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| prod_valid_i | input | 1 | Product strobe |
| prod_i | input | 32 | Signed product to accumulate |

## Verification
Every write and every product add updates the sum on the rising edge where it is sampled. All three read views therefore show the new sum straight after that edge, with no further delay. The bench drives one operation per cycle on the falling edge and updates its behavioural model at the rising edge. It then clears the strobes one time unit later and steps addr_i through the low, guard and clamp offsets, comparing each combinational result before the next falling edge. Because the reads happen with the strobes low, the read sweep cannot change the sum.

// File: rtl/acc40_pkg.sv
package acc40_pkg;
  localparam int unsigned ACC_W  = 40;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned CMD_W  = 4;

  localparam int unsigned OFF_SHIFT = 'h08;
  localparam int unsigned OFF_LO    = 'h14;
  localparam int unsigned OFF_HI    = 'h18;
  localparam int unsigned OFF_CLAMP = 'h1C;

  localparam int unsigned SH_SMALL = 1;
  localparam int unsigned SH_LARGE = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_HOLD = 4'b0000,
    CMD_SR1  = 4'b0001,
    CMD_SR4  = 4'b0100,
    CMD_SL1  = 4'b1001,
    CMD_SL4  = 4'b1100
  } shift_cmd_e;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_LO,
    SEL_HI,
    SEL_CLAMP
  } rd_sel_e;
endpackage

// File: rtl/acc40_shift.sv
module acc40_shift
  import acc40_pkg::*;
#(
  parameter int unsigned W  = ACC_W,
  parameter int unsigned CW = CMD_W
) (
  input  logic [W-1:0]  acc_i,
  input  logic [CW-1:0] cmd_i,
  output logic [W-1:0]  acc_o,
  output logic          legal_o
);
  logic [W-1:0] sr_small, sr_large, sl_small, sl_large;

  assign sr_small = {{SH_SMALL{acc_i[W-1]}}, acc_i[W-1:SH_SMALL]};
  assign sr_large = {{SH_LARGE{acc_i[W-1]}}, acc_i[W-1:SH_LARGE]};
  assign sl_small = {acc_i[W-1-SH_SMALL:0], {SH_SMALL{1'b0}}};
  assign sl_large = {acc_i[W-1-SH_LARGE:0], {SH_LARGE{1'b0}}};

  always_comb begin
    acc_o   = acc_i;
    legal_o = 1'b1;
    unique case (cmd_i)
      CMD_HOLD: acc_o = acc_i;
      CMD_SR1:  acc_o = sr_small;
      CMD_SR4:  acc_o = sr_large;
      CMD_SL1:  acc_o = sl_small;
      CMD_SL4:  acc_o = sl_large;
      default:  legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc40_clamp.sv
module acc40_clamp
  import acc40_pkg::*;
#(
  parameter int unsigned W  = ACC_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic [W-1:0]  acc_i,
  output logic [DW-1:0] clamp_o
);
  localparam int unsigned TOP_W = W - DW + 1;

  logic [TOP_W-1:0] top;
  logic             fits;

  // value fits in DW signed bits when the top bits agree with the sign
  assign top  = acc_i[W-1:DW-1];
  assign fits = (top == '0) || (top == '1);

  always_comb begin
    if (fits)            clamp_o = acc_i[DW-1:0];
    else if (acc_i[W-1]) clamp_o = {1'b1, {(DW-1){1'b0}}};
    else                 clamp_o = {1'b0, {(DW-1){1'b1}}};
  end
endmodule

// File: rtl/acc40_rdmux.sv
module acc40_rdmux
  import acc40_pkg::*;
#(
  parameter int unsigned W  = ACC_W,
  parameter int unsigned DW = DATA_W
) (
  input  rd_sel_e       sel_i,
  input  logic [W-1:0]  acc_i,
  input  logic [DW-1:0] clamp_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned GW = W - DW;

  logic [DW-1:0] hi_word;
  assign hi_word = {{(DW-GW){acc_i[W-1]}}, acc_i[W-1:DW]};

  always_comb begin
    unique case (sel_i)
      SEL_LO:    rdata_o = acc_i[DW-1:0];
      SEL_HI:    rdata_o = hi_word;
      SEL_CLAMP: rdata_o = clamp_i;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/acc40_unit.sv
module acc40_unit
  import acc40_pkg::*;
#(
  parameter int unsigned W  = ACC_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          prod_valid_i,
  input  logic [DW-1:0] prod_i
);
  localparam int unsigned GW = W - DW;

  logic [W-1:0]  acc_q, acc_d;
  logic [W-1:0]  shifted;
  logic          cmd_legal;
  logic [DW-1:0] clamp;
  logic          hit_lo, hit_hi, hit_shift, hit_clamp;
  logic          bus_owns;
  rd_sel_e       rd_sel;

  assign hit_lo    = addr_i == AW'(OFF_LO);
  assign hit_hi    = addr_i == AW'(OFF_HI);
  assign hit_shift = addr_i == AW'(OFF_SHIFT);
  assign hit_clamp = addr_i == AW'(OFF_CLAMP);
  assign bus_owns  = wr_en_i && (hit_lo || hit_hi || hit_shift);

  acc40_shift #(.W(W), .CW(CMD_W)) u_shift (
    .acc_i  (acc_q),
    .cmd_i  (wdata_i[CMD_W-1:0]),
    .acc_o  (shifted),
    .legal_o(cmd_legal)
  );

  acc40_clamp #(.W(W), .DW(DW)) u_clamp (
    .acc_i  (acc_q),
    .clamp_o(clamp)
  );

  always_comb begin
    acc_d = acc_q;
    if (bus_owns) begin
      // bus write wins over a same-cycle product
      if (hit_lo)                  acc_d = {{GW{wdata_i[DW-1]}}, wdata_i};
      else if (hit_hi)             acc_d = {wdata_i[GW-1:0], acc_q[DW-1:0]};
      else if (cmd_legal)          acc_d = shifted;
    end else if (prod_valid_i) begin
      acc_d = acc_q + {{GW{prod_i[DW-1]}}, prod_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  always_comb begin
    if (hit_lo)         rd_sel = SEL_LO;
    else if (hit_hi)    rd_sel = SEL_HI;
    else if (hit_clamp) rd_sel = SEL_CLAMP;
    else                rd_sel = SEL_NONE;
  end

  acc40_rdmux #(.W(W), .DW(DW)) u_rdmux (
    .sel_i  (rd_sel),
    .acc_i  (acc_q),
    .clamp_i(clamp),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/acc40_checks.sv
module acc40_checks
  import acc40_pkg::*;
#(
  parameter int unsigned W  = ACC_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          wr_en_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_i,
  input logic          prod_valid_i,
  input logic [DW-1:0] prod_i,
  input logic [W-1:0]  acc_i
);
  localparam int unsigned GW = W - DW;

  logic wr_lo, wr_hi, wr_sh, sh_bad, other_wr;
  assign wr_lo    = wr_en_i && addr_i == AW'(OFF_LO);
  assign wr_hi    = wr_en_i && addr_i == AW'(OFF_HI);
  assign wr_sh    = wr_en_i && addr_i == AW'(OFF_SHIFT);
  assign sh_bad   = !(wdata_i[3:0] inside {4'b0000, 4'b0001, 4'b0100, 4'b1001, 4'b1100});
  assign other_wr = wr_lo || wr_hi || wr_sh;

  assert_add_wraps_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!other_wr && prod_valid_i) |=>
      acc_i == W'($past(acc_i) + {{GW{$past(prod_i[DW-1])}}, $past(prod_i)}));

  assert_lo_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo |=> acc_i == {{GW{$past(wdata_i[DW-1])}}, $past(wdata_i)});

  assert_hi_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi |=> (acc_i[W-1:DW] == $past(wdata_i[GW-1:0])) && $stable(acc_i[DW-1:0]));

  assert_hi_view_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == AW'(OFF_HI)) |-> rdata_i == {{(DW-GW){acc_i[W-1]}}, acc_i[W-1:DW]});

  assert_clamp_pos_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == AW'(OFF_CLAMP) && !acc_i[W-1] && acc_i[W-1:DW-1] != '0)
      |-> rdata_i == {1'b0, {(DW-1){1'b1}}});

  assert_reserved_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sh && sh_bad) |=> $stable(acc_i));

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!other_wr && !prod_valid_i) |=> $stable(acc_i));
endmodule

bind acc40_unit acc40_checks #(.W(W), .DW(DW), .AW(AW)) u_checks (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .wr_en_i     (wr_en_i),
  .wdata_i     (wdata_i),
  .rdata_i     (rdata_o),
  .prod_valid_i(prod_valid_i),
  .prod_i      (prod_i),
  .acc_i       (acc_q)
);

// File: tb/acc40_unit_bench.sv
module acc40_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam longint unsigned M40 = 64'hFF_FFFF_FFFF;
  localparam logic [4:0] A_SH = 5'h08, A_LO = 5'h14, A_HI = 5'h18, A_CL = 5'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pv = 1'b0;
  logic [31:0] prod = '0;

  int checks = 0;
  int fails = 0;
  longint unsigned model = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc40_unit u_acc40_unit (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .prod_valid_i(pv), .prod_i(prod)
  );

  function automatic longint sx40(longint unsigned v);
    return v[39] ? longint'(v | ~M40) : longint'(v);
  endfunction

  function automatic logic [31:0] exp_hi(longint unsigned v);
    return {{24{v[39]}}, v[39:32]};
  endfunction

  function automatic logic [31:0] exp_clamp(longint unsigned v);
    longint s = sx40(v);
    if (s > 64'sd2147483647) return 32'h7FFF_FFFF;
    if (s < -64'sd2147483648) return 32'h8000_0000;
    return v[31:0];
  endfunction

  task automatic check_rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata, exp);
    end
  endtask

  task automatic sweep(input string tag);
    check_rd(A_LO, model[31:0], tag);
    check_rd(A_HI, exp_hi(model), tag);
    check_rd(A_CL, exp_clamp(model), tag);
  endtask

  // one operation per cycle, model updated at the edge, views checked after it
  task automatic step(input logic w, input logic [4:0] a, input logic [31:0] d,
                      input logic p, input logic [31:0] pr, input string tag);
    logic bus;
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; pv = p; prod = pr;
    @(posedge clk);
    bus = w && (a == A_LO || a == A_HI || a == A_SH);
    if (bus) begin
      if (a == A_LO) model = d[31] ? ({32'hFFFF_FFFF, d} & M40) : {32'h0, d};
      else if (a == A_HI) model = {24'h0, d[7:0], model[31:0]};
      else begin
        case (d[3:0])
          4'b0001: model = longint'(sx40(model) >>> 1) & M40;
          4'b0100: model = longint'(sx40(model) >>> 4) & M40;
          4'b1001: model = (model << 1) & M40;
          4'b1100: model = (model << 4) & M40;
          default: ;
        endcase
      end
    end else if (p) begin
      model = (model + (pr[31] ? {32'hFFFF_FFFF, pr} : {32'h0, pr})) & M40;
    end
    #1;
    wr_en = 1'b0; pv = 1'b0;
    sweep(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    sweep("R1 reset");
    rst_n = 1'b1;

    step(1, A_LO, 32'h1234_5678, 0, 0, "R3 positive load");
    step(1, A_LO, 32'h8000_0001, 0, 0, "R3 negative load");
    step(1, A_HI, 32'hABCD_EF05, 0, 0, "R4 guard load ignores upper");
    step(1, A_HI, 32'h0000_00C3, 0, 0, "R5 negative guard view");
    step(1, A_LO, 32'h0000_0010, 0, 0, "R3 reload");
    step(0, A_LO, 0, 1, 32'hFFFF_FFF0, "R2 negative product");
    step(0, A_LO, 0, 1, 32'h7FFF_FFFF, "R2 positive product");
    step(0, A_LO, 0, 1, 32'h7FFF_FFFF, "R6 clamp high");
    step(0, A_CL, 0, 0, 0, "R6 clamp read non-destructive");
    step(1, A_LO, 32'hFFFF_FFFF, 0, 0, "R3 all ones");
    step(1, A_HI, 32'h0000_007F, 0, 0, "R4 max positive");
    step(0, A_LO, 0, 1, 32'h0000_0001, "R2 wrap to min");
    step(0, A_LO, 0, 0, 0, "R6 clamp low");
    step(1, A_SH, 32'h0000_0001, 0, 0, "R7 right 1");
    step(1, A_SH, 32'h0000_0004, 0, 0, "R7 right 4");
    step(1, A_SH, 32'h0000_0000, 0, 0, "R7 hold code");
    step(1, A_LO, 32'h4000_0003, 0, 0, "R3 shift setup");
    step(1, A_SH, 32'h0000_0009, 0, 0, "R7 left 1");
    step(1, A_SH, 32'h0000_000C, 0, 0, "R7 left 4");
    step(1, A_SH, 32'hFFFF_FF0C, 0, 0, "R7 upper bits ignored");
    step(1, A_SH, 32'h0000_0002, 0, 0, "R8 reserved 0010");
    step(1, A_SH, 32'h0000_000F, 0, 0, "R8 reserved 1111");
    step(1, A_SH, 32'h0000_0008, 0, 0, "R8 reserved 1000");
    step(1, A_LO, 32'h0000_0100, 1, 32'h0000_0055, "R9 low write beats product");
    step(1, A_HI, 32'h0000_0001, 1, 32'h0000_0055, "R9 guard write beats product");
    step(1, A_SH, 32'h0000_0003, 1, 32'h0000_0055, "R9 reserved shift drops product");
    step(1, A_CL, 32'hDEAD_BEEF, 1, 32'h0000_0007, "R10 clamp write ignored, add kept");
    step(1, 5'h04, 32'hDEAD_BEEF, 0, 0, "R10 unmapped write ignored");
    check_rd(5'h04, 32'h0, "R10 unmapped read zero");
    check_rd(A_SH, 32'h0, "R10 shift read zero");
    check_rd(5'h00, 32'h0, "R10 offset zero read");

    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 5);
      logic [31:0] r = $urandom;
      logic [3:0] codes [5] = '{4'h1, 4'h4, 4'h9, 4'hC, 4'h6};
      case (op)
        0: step(1, A_LO, r, $urandom_range(0, 1), $urandom, "R3 random load");
        1: step(1, A_HI, r, 0, 0, "R4 random guard");
        2: step(1, A_SH, {28'h0, codes[$urandom_range(0, 4)]}, 0, 0, "R7 random shift");
        default: step(0, A_CL, 0, 1, r, "R2 random add");
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule